// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Logic

This block watches a bank of general purpose pins that have already been synchronised to the core clock. It keeps a captured data bit for every pin configured as an enabled input, and it turns pin activity into two interrupt request lines. Each pin can be set up on its own. It can follow its level, with a selectable active level. It can fire on one chosen edge. It can fire on any change.

The configuration arrives as plain input vectors, one bit per pin: output select, input enable, edge select, any-change select and polarity. Two mask vectors route the per-pin interrupt state to request line A and request line B. Pins that are outputs, or that have their input disabled, are left alone. A mask change takes effect on the request lines at once, with no clock edge needed.

Top module: `gpio_irq_sense`

## Requirements
- R1: A pin whose dir_i bit is 1, or whose inen_i bit is 0, is ignored in that cycle. Its data bit is held. A level-mode pin also holds its interrupt state. An edge-mode pin's interrupt state is 0 in the next cycle.
- R2: For an enabled input pin (dir_i=0, inen_i=1), data_o bit n equals the pin_i level sampled at the previous rising clock edge.
- R3: In edge mode with both_i=1 (edge_i=1), the pin's interrupt state is 1 in the cycle after a sample whose level differs from the stored data bit, for either direction of change.
- R4: In edge mode with both_i=0, polar_i=0 selects a 0 to 1 change and polar_i=1 selects a 1 to 0 change. A change in the other direction raises nothing.
- R5: An edge interrupt lasts exactly one clock, in the cycle after the edge is sampled. It returns to 0 in the next cycle unless a new qualifying edge is sampled.
- R6: In level mode (edge_i=0), the interrupt state of an enabled pin equals the sampled level XOR polar_i. It is active high for polar_i=0 and active low for polar_i=1.
- R7: irq_a_o is the OR over all pins of interrupt state AND mask_a_i. irq_b_o is the same using mask_b_i.
- R8: A change of mask_a_i or mask_b_i changes irq_a_o or irq_b_o combinationally, without a clock edge.
- R9: While rst_ni is low, all data bits and all interrupt states are 0, so data_o=0 and both request lines are low. A pin held high out of reset therefore counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Synchronised pin levels |
| dir_i | input | NUM_PINS | 1 = pin is an output, its input is ignored |
| inen_i | input | NUM_PINS | 1 = input enabled |
| edge_i | input | NUM_PINS | 1 = edge sensing, 0 = level sensing |
| both_i | input | NUM_PINS | 1 = any change fires (edge mode) |
| polar_i | input | NUM_PINS | Polarity: falling edge / active low when 1 |
| mask_a_i | input | NUM_PINS | Routing mask for request line A |
| mask_b_i | input | NUM_PINS | Routing mask for request line B |
| data_o | output | NUM_PINS | Captured data bits |
| irq_a_o | output | 1 | Interrupt request A |
| irq_b_o | output | 1 | Interrupt request B |

## Verification
The hardest case to reach from the ports is a level-mode pin that holds an active interrupt while it is being ignored, with the pin toggling underneath. The interrupt state can only be seen through the masks, so the stimulus first asserts the level, then disables the input, changes the pin, and sweeps the masks with no clock. That shows the state was kept. Random cycles mix all the modes with per-pin enables, and a bench model tracks every pin. Directed sequences cover the one-clock edge pulse, edges in the wrong direction, and the rising edge seen right after reset.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL    = 2'd0,
    SENSE_EDGE_ONE = 2'd1,
    SENSE_EDGE_ANY = 2'd2
  } sense_mode_e;

  function automatic sense_mode_e decode_mode(input logic edge_sel, input logic any_sel);
    if (!edge_sel)    return SENSE_LEVEL;
    else if (any_sel) return SENSE_EDGE_ANY;
    else              return SENSE_EDGE_ONE;
  endfunction

endpackage

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import gpio_sense_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic dir_i,
  input  logic inen_i,
  input  logic edge_i,
  input  logic both_i,
  input  logic polar_i,
  output logic data_o,
  output logic irq_o
);

  logic        data_q;
  logic        irq_q;
  logic        irq_d;
  logic        en_w;
  logic        hit_w;
  sense_mode_e mode_w;

  assign en_w   = !dir_i && inen_i;
  assign mode_w = decode_mode(edge_i, both_i);

  always_comb begin
    unique case (mode_w)
      SENSE_EDGE_ANY: hit_w = data_q ^ pin_i;
      SENSE_EDGE_ONE: hit_w = polar_i ? (data_q && !pin_i) : (!data_q && pin_i);
      default:        hit_w = pin_i ^ polar_i;
    endcase
  end

  // edge events are momentary; level state is sticky while ignored
  always_comb begin
    if (en_w)                       irq_d = hit_w;
    else if (mode_w != SENSE_LEVEL) irq_d = 1'b0;
    else                            irq_d = irq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (en_w) data_q <= pin_i;
      irq_q <= irq_d;
    end
  end

  assign data_o = data_q;
  assign irq_o  = irq_q;

  AST_IGNORED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |=> $stable(data_q)); // R1
  AST_IGNORED_EDGE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_w && edge_i) |=> !irq_q); // R1
  AST_DATA_TRACKS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_w |=> data_q == $past(pin_i)); // R2
  AST_ANY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && edge_i && both_i) |=> irq_q == (data_q != $past(data_q))); // R3
  AST_RISE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && edge_i && !both_i && !polar_i) |=> irq_q == (!$past(data_q) && data_q)); // R4
  AST_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && edge_i && !both_i && polar_i) |=> irq_q == ($past(data_q) && !data_q)); // R4
  AST_LEVEL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && !edge_i) |=> irq_q == (data_q ^ $past(polar_i))); // R6

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NUM_PINS = 16
) (
  input  logic [NUM_PINS-1:0] state_i,
  input  logic [NUM_PINS-1:0] mask_a_i,
  input  logic [NUM_PINS-1:0] mask_b_i,
  output logic                irq_a_o,
  output logic                irq_b_o
);

  assign irq_a_o = |(state_i & mask_a_i);
  assign irq_b_o = |(state_i & mask_b_i);

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] inen_i,
  input  logic [NUM_PINS-1:0] edge_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] polar_i,
  input  logic [NUM_PINS-1:0] mask_a_i,
  input  logic [NUM_PINS-1:0] mask_b_i,
  output logic [NUM_PINS-1:0] data_o,
  output logic                irq_a_o,
  output logic                irq_b_o
);

  logic [NUM_PINS-1:0] state_w;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_pin_sense u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[g]),
      .dir_i  (dir_i[g]),
      .inen_i (inen_i[g]),
      .edge_i (edge_i[g]),
      .both_i (both_i[g]),
      .polar_i(polar_i[g]),
      .data_o (data_o[g]),
      .irq_o  (state_w[g])
    );
  end

  gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_merge (
    .state_i (state_w),
    .mask_a_i(mask_a_i),
    .mask_b_i(mask_b_i),
    .irq_a_o (irq_a_o),
    .irq_b_o (irq_b_o)
  );

  AST_MASK_A_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_a_i == '0) |-> !irq_a_o); // R7
  AST_MASK_B_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_b_i == '0) |-> !irq_b_o); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == '0 && !irq_a_o && !irq_b_o)); // R9

endmodule

// File: tb/sim_gpio_irq_sense.sv
`timescale 1ns/1ps
module sim_gpio_irq_sense;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin = '0, dir = '0, inen = '0, edg = '0, both = '0, polar = '0;
  logic [W-1:0] mska = '0, mskb = '0;
  logic [W-1:0] data;
  logic         irqa, irqb;

  logic [W-1:0] m_data = '0, m_state = '0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_irq_sense #(.NUM_PINS(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dir_i(dir), .inen_i(inen),
    .edge_i(edg), .both_i(both), .polar_i(polar), .mask_a_i(mska), .mask_b_i(mskb),
    .data_o(data), .irq_a_o(irqa), .irq_b_o(irqb)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clock();
    for (int i = 0; i < W; i++) begin
      logic en, o, n;
      en = !dir[i] && inen[i];
      o = m_data[i];
      n = pin[i];
      if (en) begin
        m_data[i] = n;
        if (edg[i]) m_state[i] = both[i] ? (o != n) : (polar[i] ? (o && !n) : (!o && n));
        else        m_state[i] = n ^ polar[i];
      end else if (edg[i]) m_state[i] = 1'b0;
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_clock();
    #1;
    chk({tag, " data"}, data, m_data);
    chk({tag, " irqA R7"}, {15'd0, irqa}, {15'd0, |(m_state & mska)});
    chk({tag, " irqB R7"}, {15'd0, irqb}, {15'd0, |(m_state & mskb)});
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    pin = 16'h0001;
    #5;
    // R9: outputs quiet during reset
    mska = '1; mskb = '1; #1;
    chk("R9 reset data", data, '0);
    chk("R9 reset irq", {14'd0, irqa, irqb}, '0);
    @(negedge clk); rst_n = 1'b1;
    // R9/R4: pin0 high from reset is a rising edge
    inen = '1; edg = '1; mska = 16'h0001; mskb = '0;
    cyc("R9 rise after reset");
    chk("R4 rise fired", {15'd0, irqa}, 16'd1);
    cyc("R5 pulse end");
    chk("R5 one clock", {15'd0, irqa}, 16'd0);
    // R4: falling edge with rising polarity ignored; then falling polarity
    pin[0] = 1'b0; cyc("R4 wrong dir");
    chk("R4 no fire on fall", {15'd0, irqa}, 16'd0);
    polar[0] = 1'b1; pin[0] = 1'b1; cyc("R4 setup");
    pin[0] = 1'b0; cyc("R4 fall");
    chk("R4 fall fired", {15'd0, irqa}, 16'd1);
    // R3: both edges
    both[0] = 1'b1; pin[0] = 1'b1; cyc("R3 rise");
    chk("R3 rise", {15'd0, irqa}, 16'd1);
    pin[0] = 1'b0; cyc("R3 fall");
    chk("R3 fall", {15'd0, irqa}, 16'd1);
    cyc("R3 steady");
    chk("R3 steady", {15'd0, irqa}, 16'd0);
    // R6: level mode, active low on pin1, routed to B
    edg = '0; both = '0; polar = 16'h0002; mska = '0; mskb = 16'h0002;
    pin[1] = 1'b0; cyc("R6 active low");
    chk("R6 low asserts", {15'd0, irqb}, 16'd1);
    // R1: disable and toggle; data and level state held
    inen[1] = 1'b0; pin[1] = 1'b1; cyc("R1 inen off");
    chk("R1 data held", {15'd0, data[1]}, 16'd0);
    chk("R1 state held", {15'd0, irqb}, 16'd1);
    inen[1] = 1'b1; dir[1] = 1'b1; cyc("R1 dir out");
    chk("R1 dir held", {15'd0, irqb}, 16'd1);
    // R8: mask sweep without a clock edge
    mskb = '0; #0.5;
    chk("R8 mask off", {15'd0, irqb}, 16'd0);
    mska = 16'h0002; #0.5;
    chk("R8 mask on A", {15'd0, irqa}, 16'd1);
    dir = '0;
    cyc("R6 re-enable");
    chk("R6 high clears", {15'd0, irqa}, 16'd0);
    // R1: edge pin disabled loses pulse
    edg[2] = 1'b1; both[2] = 1'b1; mska = 16'h0004; pin[2] = 1'b1; cyc("R1 edge");
    chk("R3 pin2", {15'd0, irqa}, 16'd1);
    inen[2] = 1'b0; pin[2] = 1'b0; cyc("R1 edge off");
    chk("R1 edge cleared", {15'd0, irqa}, 16'd0);
    // random mix: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 3000; k++) begin
      pin   = 16'($urandom);
      if (k % 16 == 0) begin
        dir   = 16'($urandom) & 16'($urandom);
        inen  = 16'($urandom) | 16'($urandom);
        edg   = 16'($urandom);
        both  = 16'($urandom);
        polar = 16'($urandom);
      end
      mska = 16'($urandom) & 16'($urandom);
      mskb = 16'($urandom) & 16'($urandom);
      cyc("R2 random");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule